// File: doc/BRIEF.md
# Floating-point state image sequencer

This block moves the floating-point unit's architectural state to and from a memory image, one 16-bit word per beat. A one-cycle start pulse carries the effective address, the ModRM reg and mod fields and a protected-mode flag. Reg field 0 selects a save and reg field 1 selects a restore. Before any beat is issued, the block validates the request and answers a bad one with a single-cycle fault pulse.

A save gathers the control, status and tag words, the instruction and operand pointers and eight 80-bit registers from its inputs. It writes them to the image and then puts the control, status, tag and stack-top outputs into their initialised values. A restore reads the same image and rebuilds those outputs, together with the pointer and register outputs. The tag word is two bits per register inside the unit and one bit per register in the image.

Each operation touches the first 160 bytes of the 512-byte image, as 80 ascending word beats. When an operation completes, the block raises a done pulse and reports a modelled instruction latency. The block does no arithmetic on register contents.

Top module: `fp_image_seq`

## Requirements
- R1: After reset there is no memory request and no fault or done pulse. The control output is 0x037F, status is 0, the tag word is 0xFFFF, the stack top is 0, and the pointer, register and latency outputs are 0.
- R2: A start whose effective address has any of bits 3:0 set produces a gpFault pulse of one cycle, in the cycle after start, and issues no memory request. This check takes precedence over R3.
- R3: An aligned start whose reg field is greater than 1, or whose mod field equals 3, produces a udFault pulse of one cycle, in the cycle after start, and issues no memory request.
- R4: A valid operation issues 80 beats, starting in the cycle after start. Beat k is at address base+2k, for k from 0 to 79 in ascending order. Each beat holds its address until memReady is high. memWe is 1 for a save and 0 for a restore.
- R5: Save image contents, by byte offset:
  - 0: control word.
  - 2: status word, with bits 13:11 replaced by the stack top.
  - 4: the tag byte, with 0 in the byte at offset 5.
  - 6: operand-offset bits 19:16 in bits 15:12, and 0 elsewhere.
  - 8 and 10: instruction offset, low half then high half.
  - 12: instruction segment.
  - 16 and 18: operand offset, low half then high half.
  - 20: operand segment.
  - 32+16i: register i as five words, least significant first, followed by three zero words.
  - Every other header word is 0.
- R6: Bit i of the saved tag byte is 1 exactly when tag bits 2i+1:2i equal 2'b11.
- R7: When a save completes, in its done cycle, the control output becomes 0x037F, status becomes 0, the tag word becomes 0xFFFF and the stack top becomes 0. These four outputs do not change while the operation runs. The pointer and register outputs keep their values.
- R8: When a restore completes, in its done cycle, the outputs are set as follows:
  - control: the stored word ANDed with 0x1F3F, then ORed with 0x0040.
  - status: the stored word with bits 13:11 cleared.
  - stack top: stored status bits 13:11.
  - tag: each stored tag bit i expands to 2'b11 when set and 2'b00 when clear.
  - instruction and operand pointers: loaded from the image.
  - operand offset: the dword at offset 16 ORed with word-6 bits 15:12 shifted to bits 19:16.
  - registers: loaded from their five words.
  - Padding words do not affect any output.
- R9: done is a one-cycle pulse in the cycle after the final beat is accepted. In that same cycle cycleCost becomes 56 for a save or 34 for a restore in protected mode, and 67 or 44 otherwise. cycleCost holds that value until the next completion.
- R10: A start that arrives while an operation is running is ignored. The running sequence continues unchanged and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request |
| modrmReg | input | 3 | ModRM reg field: 0 save, 1 restore |
| modrmMod | input | 2 | ModRM mod field |
| effAddr | input | 32 | Byte address of the image |
| protMode | input | 1 | Protected-mode flag for latency |
| fpCtrlIn | input | 16 | Control word to save |
| fpStatIn | input | 16 | Status word to save |
| fpTopIn | input | 3 | Stack top to save |
| fpTagIn | input | 16 | Two-bit tags to save |
| instrOffIn | input | 32 | Instruction pointer offset to save |
| instrSegIn | input | 16 | Instruction pointer segment to save |
| operOffIn | input | 32 | Operand pointer offset to save |
| operSegIn | input | 16 | Operand pointer segment to save |
| fpRegsIn | input | 640 | Eight 80-bit registers to save, register i at bits 80i+79:80i |
| memReq | output | 1 | Beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | 32 | Beat byte address |
| memWdata | output | 16 | Write data |
| memReady | input | 1 | Beat accepted this cycle |
| memRdata | input | 16 | Read data, valid with memReady |
| fpCtrl | output | 16 | Control word |
| fpStat | output | 16 | Status word without stack top |
| fpTop | output | 3 | Stack top |
| fpTag | output | 16 | Two-bit tags |
| instrOff | output | 32 | Restored instruction offset |
| instrSeg | output | 16 | Restored instruction segment |
| operOff | output | 32 | Restored operand offset |
| operSeg | output | 16 | Restored operand segment |
| fpRegs | output | 640 | Restored registers |
| gpFault | output | 1 | Misalignment fault pulse |
| udFault | output | 1 | Invalid-encoding fault pulse |
| done | output | 1 | Completion pulse |
| cycleCost | output | 8 | Modelled latency of the last operation |

## Verification
A word counter that slips would show up at the very next beat, as an address that no longer equals base+2k or as write data taken from the wrong header field. A stale operation latch would turn memWe or the latency value wrong on the first beat or at done. Restore capture errors stay hidden inside the block until the done cycle, so the bench compares every restored output there, and compares the control, status, tag and stack-top outputs on every beat to catch an early commit. The bench drives its memory model with irregular readiness, so a mishandled stall shows up as a repeated or skipped beat address.

// File: rtl/fp_image_pkg.sv
package fp_image_pkg;
  localparam int WORD_W      = 16;
  localparam int NREG        = 8;
  localparam int REG_W       = 80;
  localparam int TAG_W       = 2 * NREG;
  localparam int TOP_W       = 3;
  localparam int TOP_LSB     = 11;
  localparam int OFF_W       = 32;
  localparam int SEG_W       = 16;
  localparam int HDR_WORDS   = 16;
  localparam int SLOT_WORDS  = 8;
  localparam int REG_WORDS   = REG_W / WORD_W;
  localparam int TOTAL_WORDS = HDR_WORDS + NREG * SLOT_WORDS;
  localparam int IDX_W       = $clog2(TOTAL_WORDS);
  localparam int ALIGN_BITS  = 4;
  localparam int OPHI_W      = 4;
  localparam int OPHI_LSB    = 16;
  localparam int W6_LSB      = 12;
  localparam int COST_W      = 8;

  localparam logic [WORD_W-1:0] CTRL_INIT  = 16'h037F;
  localparam logic [WORD_W-1:0] CTRL_KEEP  = 16'h1F3F;
  localparam logic [WORD_W-1:0] CTRL_FORCE = 16'h0040;
  localparam logic [WORD_W-1:0] TOP_MASK   = 16'h3800;

  typedef struct packed {
    logic capture;
    logic commitSave;
    logic commitRestore;
  } seqStrobeT;
endpackage

// File: rtl/fp_image_ctl.sv
module fp_image_ctl
  import fp_image_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int COST_SAVE_PM = 56,
  parameter int COST_SAVE_RM = 67,
  parameter int COST_RST_PM  = 34,
  parameter int COST_RST_RM  = 44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        modrmReg,
  input  logic [1:0]        modrmMod,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic              protMode,
  input  logic              memReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  wordIdx,
  output seqStrobeT         strobe,
  output logic              gpFault,
  output logic              udFault,
  output logic              done,
  output logic [COST_W-1:0] cycleCost
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  typedef enum logic {S_IDLE, S_RUN} stateT;
  stateT             state;
  logic              isSave;
  logic              isProt;
  logic [ADDR_W-1:0] baseAddr;
  logic              badAlign;
  logic              badCode;
  logic              lastBeat;

  assign badAlign = |effAddr[ALIGN_BITS-1:0];
  assign badCode  = (modrmReg > 3'd1) || (modrmMod == 2'd3);
  assign memReq   = (state == S_RUN);
  assign memWe    = memReq && isSave;
  assign memAddr  = baseAddr + {{(ADDR_W-IDX_W-1){1'b0}}, wordIdx, 1'b0};
  assign lastBeat = memReq && memReady && (wordIdx == LAST_IDX);

  assign strobe.capture       = memReq && memReady && !isSave;
  assign strobe.commitSave    = lastBeat && isSave;
  assign strobe.commitRestore = lastBeat && !isSave;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      isSave    <= 1'b0;
      isProt    <= 1'b0;
      baseAddr  <= '0;
      wordIdx   <= '0;
      gpFault   <= 1'b0;
      udFault   <= 1'b0;
      done      <= 1'b0;
      cycleCost <= '0;
    end else begin
      gpFault <= 1'b0;
      udFault <= 1'b0;
      done    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (badAlign) begin
              gpFault <= 1'b1;
            end else if (badCode) begin
              udFault <= 1'b1;
            end else begin
              state    <= S_RUN;
              wordIdx  <= '0;
              isSave   <= (modrmReg == 3'd0);
              isProt   <= protMode;
              baseAddr <= effAddr;
            end
          end
        end
        S_RUN: begin
          if (memReady) begin
            if (wordIdx == LAST_IDX) begin
              state     <= S_IDLE;
              done      <= 1'b1;
              cycleCost <= isSave ? COST_W'(isProt ? COST_SAVE_PM : COST_SAVE_RM)
                                  : COST_W'(isProt ? COST_RST_PM : COST_RST_RM);
            end else begin
              wordIdx <= wordIdx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_gp_no_access: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> !memReq);
  a_r3_ud_no_access: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> !memReq);
  a_r9_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gpFault, udFault, done}));
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> (!memReq || (memAddr == $past(memAddr) + ADDR_W'(2))));
  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memReady));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && start && !memReady) |=> memReq);
endmodule

// File: rtl/fp_image_dp.sv
module fp_image_dp
  import fp_image_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobeT             strobe,
  input  logic [IDX_W-1:0]      wordIdx,
  input  logic [WORD_W-1:0]     memRdata,
  input  logic [WORD_W-1:0]     fpCtrlIn,
  input  logic [WORD_W-1:0]     fpStatIn,
  input  logic [TOP_W-1:0]      fpTopIn,
  input  logic [TAG_W-1:0]      fpTagIn,
  input  logic [OFF_W-1:0]      instrOffIn,
  input  logic [SEG_W-1:0]      instrSegIn,
  input  logic [OFF_W-1:0]      operOffIn,
  input  logic [SEG_W-1:0]      operSegIn,
  input  logic [NREG*REG_W-1:0] fpRegsIn,
  output logic [WORD_W-1:0]     memWdata,
  output logic [WORD_W-1:0]     fpCtrl,
  output logic [WORD_W-1:0]     fpStat,
  output logic [TOP_W-1:0]      fpTop,
  output logic [TAG_W-1:0]      fpTag,
  output logic [OFF_W-1:0]      instrOff,
  output logic [SEG_W-1:0]      instrSeg,
  output logic [OFF_W-1:0]      operOff,
  output logic [SEG_W-1:0]      operSeg,
  output logic [NREG*REG_W-1:0] fpRegs
);
  localparam int SLOT_SH = $clog2(SLOT_WORDS);
  localparam int HALF_W  = OFF_W / 2;

  logic              inHdr;
  logic [IDX_W-1:0]  slotIdx;
  int                regSel;
  int                wSel;
  logic [NREG-1:0]   tagPacked;
  logic [TAG_W-1:0]  tagWide;
  logic [WORD_W-1:0] rCtrlRaw;
  logic [WORD_W-1:0] rStatRaw;
  logic [NREG-1:0]   rTagRaw;
  logic [OPHI_W-1:0] rOpHi;
  logic [HALF_W-1:0] rOpLo;
  logic [HALF_W-1:0] rOpUp;

  assign inHdr   = wordIdx < IDX_W'(HDR_WORDS);
  assign slotIdx = wordIdx - IDX_W'(HDR_WORDS);

  always_comb begin
    regSel = int'(slotIdx >> SLOT_SH);
    wSel   = int'(slotIdx & IDX_W'(SLOT_WORDS - 1));
  end

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    assign tagPacked[g]       = &fpTagIn[2*g +: 2];
    assign tagWide[2*g +: 2]  = {2{rTagRaw[g]}};
  end

  always_comb begin
    memWdata = '0;
    if (inHdr) begin
      case (int'(wordIdx))
        0:  memWdata = fpCtrlIn;
        1:  memWdata = (fpStatIn & ~TOP_MASK) | (WORD_W'(fpTopIn) << TOP_LSB);
        2:  memWdata = WORD_W'(tagPacked);
        3:  memWdata = WORD_W'(operOffIn[OPHI_LSB +: OPHI_W]) << W6_LSB;
        4:  memWdata = instrOffIn[HALF_W-1:0];
        5:  memWdata = instrOffIn[OFF_W-1:HALF_W];
        6:  memWdata = instrSegIn;
        8:  memWdata = operOffIn[HALF_W-1:0];
        9:  memWdata = operOffIn[OFF_W-1:HALF_W];
        10: memWdata = operSegIn;
        default: memWdata = '0;
      endcase
    end else if (wSel < REG_WORDS) begin
      memWdata = fpRegsIn[regSel*REG_W + wSel*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rCtrlRaw <= '0;
      rStatRaw <= '0;
      rTagRaw  <= '0;
      rOpHi    <= '0;
      rOpLo    <= '0;
      rOpUp    <= '0;
      fpCtrl   <= CTRL_INIT;
      fpStat   <= '0;
      fpTop    <= '0;
      fpTag    <= '1;
      instrOff <= '0;
      instrSeg <= '0;
      operOff  <= '0;
      operSeg  <= '0;
      fpRegs   <= '0;
    end else begin
      if (strobe.capture) begin
        if (inHdr) begin
          case (int'(wordIdx))
            0:  rCtrlRaw <= memRdata;
            1:  rStatRaw <= memRdata;
            2:  rTagRaw  <= memRdata[NREG-1:0];
            3:  rOpHi    <= memRdata[W6_LSB +: OPHI_W];
            4:  instrOff[HALF_W-1:0]     <= memRdata;
            5:  instrOff[OFF_W-1:HALF_W] <= memRdata;
            6:  instrSeg <= memRdata;
            8:  rOpLo    <= memRdata;
            9:  rOpUp    <= memRdata;
            10: operSeg  <= memRdata;
            default: ;
          endcase
        end else if (wSel < REG_WORDS) begin
          fpRegs[regSel*REG_W + wSel*WORD_W +: WORD_W] <= memRdata;
        end
      end
      if (strobe.commitSave) begin
        fpCtrl <= CTRL_INIT;
        fpStat <= '0;
        fpTop  <= '0;
        fpTag  <= '1;
      end
      if (strobe.commitRestore) begin
        fpCtrl  <= (rCtrlRaw & CTRL_KEEP) | CTRL_FORCE;
        fpStat  <= rStatRaw & ~TOP_MASK;
        fpTop   <= rStatRaw[TOP_LSB +: TOP_W];
        fpTag   <= tagWide;
        operOff <= {rOpUp, rOpLo} | (OFF_W'(rOpHi) << OPHI_LSB);
      end
    end
  end

  a_r7_save_reinit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitSave |=> (fpCtrl == CTRL_INIT && fpStat == '0 && fpTop == '0 && fpTag == '1));
  a_r8_ctrl_forced: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitRestore |=> (fpCtrl[6] && fpCtrl[15:13] == 3'b000 && fpCtrl[7] == 1'b0));
  a_r8_status_no_top: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitRestore |=> (fpStat[TOP_LSB +: TOP_W] == '0));
  a_r8_tag_pairs: assert property (@(posedge clk) disable iff (!rstN)
    (fpTag & 16'h5555) == ((fpTag >> 1) & 16'h5555));
  a_r7_hold_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commitSave || strobe.commitRestore) |=> $stable(fpTag) && $stable(fpTop));
endmodule

// File: rtl/fp_image_seq.sv
module fp_image_seq
  import fp_image_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [2:0]            modrmReg,
  input  logic [1:0]            modrmMod,
  input  logic [ADDR_W-1:0]     effAddr,
  input  logic                  protMode,
  input  logic [WORD_W-1:0]     fpCtrlIn,
  input  logic [WORD_W-1:0]     fpStatIn,
  input  logic [TOP_W-1:0]      fpTopIn,
  input  logic [TAG_W-1:0]      fpTagIn,
  input  logic [OFF_W-1:0]      instrOffIn,
  input  logic [SEG_W-1:0]      instrSegIn,
  input  logic [OFF_W-1:0]      operOffIn,
  input  logic [SEG_W-1:0]      operSegIn,
  input  logic [NREG*REG_W-1:0] fpRegsIn,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWdata,
  input  logic                  memReady,
  input  logic [WORD_W-1:0]     memRdata,
  output logic [WORD_W-1:0]     fpCtrl,
  output logic [WORD_W-1:0]     fpStat,
  output logic [TOP_W-1:0]      fpTop,
  output logic [TAG_W-1:0]      fpTag,
  output logic [OFF_W-1:0]      instrOff,
  output logic [SEG_W-1:0]      instrSeg,
  output logic [OFF_W-1:0]      operOff,
  output logic [SEG_W-1:0]      operSeg,
  output logic [NREG*REG_W-1:0] fpRegs,
  output logic                  gpFault,
  output logic                  udFault,
  output logic                  done,
  output logic [COST_W-1:0]     cycleCost
);
  logic [IDX_W-1:0] wordIdx;
  seqStrobeT        strobe;

  fp_image_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .modrmReg(modrmReg), .modrmMod(modrmMod),
    .effAddr(effAddr), .protMode(protMode), .memReady(memReady), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .wordIdx(wordIdx), .strobe(strobe),
    .gpFault(gpFault), .udFault(udFault), .done(done), .cycleCost(cycleCost)
  );

  fp_image_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx), .memRdata(memRdata),
    .fpCtrlIn(fpCtrlIn), .fpStatIn(fpStatIn), .fpTopIn(fpTopIn), .fpTagIn(fpTagIn),
    .instrOffIn(instrOffIn), .instrSegIn(instrSegIn), .operOffIn(operOffIn),
    .operSegIn(operSegIn), .fpRegsIn(fpRegsIn), .memWdata(memWdata),
    .fpCtrl(fpCtrl), .fpStat(fpStat), .fpTop(fpTop), .fpTag(fpTag),
    .instrOff(instrOff), .instrSeg(instrSeg), .operOff(operOff), .operSeg(operSeg),
    .fpRegs(fpRegs)
  );
endmodule

// File: tb/fp_image_seq_bench.sv
module fp_image_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN;
  logic          start;
  logic [2:0]    modrmReg;
  logic [1:0]    modrmMod;
  logic [31:0]   effAddr;
  logic          protMode;
  logic [15:0]   fpCtrlIn, fpStatIn, instrSegIn, operSegIn;
  logic [2:0]    fpTopIn;
  logic [15:0]   fpTagIn;
  logic [31:0]   instrOffIn, operOffIn;
  logic [639:0]  fpRegsIn;
  logic          memReq, memWe, memReady;
  logic [31:0]   memAddr;
  logic [15:0]   memWdata, memRdata;
  logic [15:0]   fpCtrl, fpStat, fpTag, instrSeg, operSeg;
  logic [2:0]    fpTop;
  logic [31:0]   instrOff, operOff;
  logic [639:0]  fpRegs;
  logic          gpFault, udFault, done;
  logic [7:0]    cycleCost;

  fp_image_seq u_fp_image_seq (
    .clk(clk), .rstN(rstN), .start(start), .modrmReg(modrmReg), .modrmMod(modrmMod),
    .effAddr(effAddr), .protMode(protMode), .fpCtrlIn(fpCtrlIn), .fpStatIn(fpStatIn),
    .fpTopIn(fpTopIn), .fpTagIn(fpTagIn), .instrOffIn(instrOffIn), .instrSegIn(instrSegIn),
    .operOffIn(operOffIn), .operSegIn(operSegIn), .fpRegsIn(fpRegsIn), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .fpCtrl(fpCtrl), .fpStat(fpStat), .fpTop(fpTop), .fpTag(fpTag),
    .instrOff(instrOff), .instrSeg(instrSeg), .operOff(operOff), .operSeg(operSeg),
    .fpRegs(fpRegs), .gpFault(gpFault), .udFault(udFault), .done(done), .cycleCost(cycleCost)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [15:0] mem [0:1023];

  logic [15:0]  eCtrl, eStat, eTag, eIpSeg, eOpSeg;
  logic [2:0]   eTop;
  logic [31:0]  eIpOff, eOpOff;
  logic [639:0] eRegs;

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input string req, input bit ok, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  task automatic chkState(input string req);
    chk(req, fpCtrl == eCtrl && fpStat == eStat && fpTop == eTop && fpTag == eTag,
        $sformatf("ctrl/stat/top/tag actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                  fpCtrl, fpStat, fpTop, fpTag, eCtrl, eStat, eTop, eTag));
    chk(req, instrOff == eIpOff && instrSeg == eIpSeg && operOff == eOpOff &&
             operSeg == eOpSeg && fpRegs == eRegs,
        $sformatf("pointers actual=%h:%h %h:%h expected=%h:%h %h:%h (regs match=%0d)",
                  instrSeg, instrOff, operSeg, operOff, eIpSeg, eIpOff, eOpSeg, eOpOff,
                  fpRegs == eRegs));
  endtask

  task automatic loadInputs(input logic [15:0] tag);
    fpCtrlIn   = nextRand()[15:0];
    fpStatIn   = nextRand()[15:0];
    fpTopIn    = nextRand()[2:0];
    fpTagIn    = tag;
    instrOffIn = nextRand();
    instrSegIn = nextRand()[15:0];
    operOffIn  = nextRand();
    operSegIn  = nextRand()[15:0];
    for (int i = 0; i < 20; i++) fpRegsIn[32*i +: 32] = nextRand();
  endtask

  task automatic runFault(input logic [2:0] rg, input logic [1:0] md, input logic [31:0] addr,
                          input bit expGp, input string req);
    @(negedge clk);
    start = 1'b1; modrmReg = rg; modrmMod = md; effAddr = addr; protMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, gpFault == expGp && udFault == !expGp && !memReq && !done,
        $sformatf("gp/ud/req actual=%0d/%0d/%0d expected=%0d/%0d/0",
                  gpFault, udFault, memReq, expGp, !expGp));
    @(negedge clk);
    chk(req, !gpFault && !udFault && !memReq,
        $sformatf("after pulse gp/ud/req actual=%0d/%0d/%0d expected=0/0/0", gpFault, udFault, memReq));
    chkState(req);
  endtask

  task automatic runOp(input bit isSave, input bit prot, input logic [31:0] addr,
                       input int midStart, input bit alwaysReady);
    logic [15:0] expW [80];
    int k = 0;
    int guard = 0;
    int wb = int'(addr[10:1]);
    logic [15:0] w3;
    string lbl;
    for (int j = 0; j < 80; j++) expW[j] = 16'h0;
    if (isSave) begin
      expW[0] = fpCtrlIn;
      expW[1] = (fpStatIn & 16'hC7FF) | (16'(fpTopIn) << 11);
      for (int i = 0; i < 8; i++)
        expW[2][i] = (fpTagIn[2*i +: 2] == 2'b11);
      expW[3] = {operOffIn[19:16], 12'h000};
      expW[4] = instrOffIn[15:0];  expW[5] = instrOffIn[31:16];
      expW[6] = instrSegIn;
      expW[8] = operOffIn[15:0];   expW[9] = operOffIn[31:16];
      expW[10] = operSegIn;
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 5; j++)
          expW[16 + 8*i + j] = fpRegsIn[80*i + 16*j +: 16];
    end
    @(negedge clk);
    start = 1'b1; modrmReg = isSave ? 3'd0 : 3'd1; modrmMod = 2'd0;
    effAddr = addr; protMode = prot;
    @(negedge clk);
    start = 1'b0;
    while (k < 80 && guard < 4000) begin
      bit rdy;
      guard++;
      rdy = alwaysReady || (nextRand() % 3 != 0);
      lbl = (k == 2 && isSave) ? "R6" : (isSave ? "R5" : "R4");
      chk(lbl, memReq && !done && memAddr == addr + 32'(2*k) && memWe == isSave &&
               (!isSave || memWdata == expW[k]),
          $sformatf("beat %0d req/we/addr/data actual=%0d/%0d/%h/%h expected=1/%0d/%h/%h",
                    k, memReq, memWe, memAddr, memWdata, isSave, addr + 32'(2*k), expW[k]));
      chk(isSave ? "R7" : "R8", fpCtrl == eCtrl && fpTag == eTag && fpTop == eTop && fpStat == eStat,
          $sformatf("early update ctrl/tag actual=%h/%h expected=%h/%h", fpCtrl, fpTag, eCtrl, eTag));
      memReady = rdy;
      memRdata = isSave ? 16'h0 : mem[(wb + k) & 1023];
      if (k == midStart) begin
        start = 1'b1; modrmReg = isSave ? 3'd1 : 3'd0;
        effAddr = addr + 32'h40; protMode = !prot;
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) begin
        if (isSave) mem[(wb + k) & 1023] = expW[k];
        k++;
      end
    end
    memReady = 1'b0;
    if (isSave) begin
      eCtrl = 16'h037F; eStat = 16'h0; eTag = 16'hFFFF; eTop = 3'd0;
    end else begin
      eCtrl = (mem[wb] & 16'h1F3F) | 16'h0040;
      eStat = mem[wb + 1] & 16'hC7FF;
      eTop  = mem[wb + 1][13:11];
      for (int i = 0; i < 8; i++) eTag[2*i +: 2] = mem[wb + 2][i] ? 2'b11 : 2'b00;
      w3 = mem[wb + 3];
      eIpOff = {mem[wb + 5], mem[wb + 4]};
      eIpSeg = mem[wb + 6];
      eOpOff = {mem[wb + 9], mem[wb + 8]} | (32'(w3[15:12]) << 16);
      eOpSeg = mem[wb + 10];
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 5; j++)
          eRegs[80*i + 16*j +: 16] = mem[wb + 16 + 8*i + j];
    end
    chk("R9", done && !memReq,
        $sformatf("done/req actual=%0d/%0d expected=1/0", done, memReq));
    chk("R9", cycleCost == (isSave ? (prot ? 8'd56 : 8'd67) : (prot ? 8'd34 : 8'd44)),
        $sformatf("cost actual=%0d expected=%0d", cycleCost,
                  isSave ? (prot ? 56 : 67) : (prot ? 34 : 44)));
    chkState(isSave ? "R7" : "R8");
    @(negedge clk);
    chk("R10", !done && !memReq && !gpFault && !udFault,
        $sformatf("after done done/req actual=%0d/%0d expected=0/0", done, memReq));
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; modrmReg = 3'd0; modrmMod = 2'd0; effAddr = 32'h0;
    protMode = 1'b0; memReady = 1'b0; memRdata = 16'h0;
    fpRegsIn = '0;
    loadInputs(16'h0000);
    for (int i = 0; i < 1024; i++) mem[i] = nextRand()[15:0];
    eCtrl = 16'h037F; eStat = 16'h0; eTag = 16'hFFFF; eTop = 3'd0;
    eIpOff = 32'h0; eIpSeg = 16'h0; eOpOff = 32'h0; eOpSeg = 16'h0; eRegs = '0;
    repeat (3) @(negedge clk);
    chk("R1", !memReq && !done && !gpFault && !udFault && cycleCost == 8'd0,
        $sformatf("in reset req/done/cost actual=%0d/%0d/%0d expected=0/0/0", memReq, done, cycleCost));
    rstN = 1'b1;
    @(negedge clk);
    chkState("R1");

    runFault(3'd0, 2'd0, 32'h0000_0104, 1'b1, "R2");
    runFault(3'd5, 2'd3, 32'h0000_0108, 1'b1, "R2");
    runFault(3'd2, 2'd0, 32'h0000_0100, 1'b0, "R3");
    runFault(3'd1, 2'd3, 32'h0000_0100, 1'b0, "R3");

    loadInputs(16'b11_00_01_11_10_11_11_00);
    runOp(1'b1, 1'b1, 32'h0000_0100, -1, 1'b0);

    runOp(1'b0, 1'b0, 32'h0000_0200, -1, 1'b0);

    loadInputs(16'b11_11_11_11_00_00_10_11);
    fpTopIn = 3'd5;
    runOp(1'b1, 1'b0, 32'h0000_0300, 7, 1'b1);

    runOp(1'b0, 1'b1, 32'h0000_0300, 40, 1'b0);
    chk("R8", fpTag == 16'b11_11_11_11_00_00_00_11 && fpTop == 3'd5,
        $sformatf("round trip tag/top actual=%h/%0d expected=%h/5", fpTag, fpTop,
                  16'b11_11_11_11_00_00_00_11));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule